// File: doc/BRIEF.md
# Fast-Boot Serial Read Responder

This block is the device side of a serial flash that can send boot code without receiving a read command. A 32-bit boot configuration word holds three fields: an active-low enable, a two-bit code for the dummy-clock count, and a start address aligned to 16 bytes. After power-on, after a hardware reset pin pulse or after a software reset request, the block is armed. If the enable bit is cleared, the first chip-select-low window runs as a boot stream. The configured number of dummy clocks pass first. Then bytes leave in sequence from a behavioural byte array, starting at the configured address.

The serial clock and chip select are assumed to be already synchronous to the system clock, which oversamples them. Bytes leave on one lane or on four lanes, as chosen by the quad-enable input. Only the first window after a reset streams. Every later window is handed to normal command decoding, which is shown by `cmd_mode`. If chip select rises before one full byte has been sampled, a sticky error flag is set. The configuration word and the byte array are loaded through plain parallel write ports.

Top module: `fast_boot_resp`

## Requirements
- R1: After power-on reset (`por_n`), `cfg_q` reads 32'hFFFF_FFFF. With this value the first window does not stream: `cmd_mode` is 1 and `io_oe` stays 0.
- R2: Bit 0 of the configuration word enables boot streaming when it is 0 and disables it when it is 1.
- R3: Configuration bits 2:1 give the dummy count in serial-clock rising edges after chip select falls: 0→6, 1→8, 2→10, 3→12. No output is enabled until that many rising edges have occurred. The first data unit is driven on the next falling edge.
- R4: The first byte comes from address `{cfg_q[ADDR_W-1:4], 4'b0000}`. Configuration bit 3, and bits at ADDR_W and above, have no effect.
- R5: With quad disabled, each byte leaves MSB first on `io_out[1]`, one bit per serial-clock falling edge, and `io_oe` is 4'b0010.
- R6: With quad enabled, each byte leaves as two nibbles, high nibble first, on `io_out[3:0]` (bit 3 carries the nibble MSB), and `io_oe` is 4'b1111.
- R7: The lane mode is captured when chip select falls. A change of `quad_en` during a window has no effect on that window.
- R8: Bytes come from consecutive addresses and wrap from 2^ADDR_W-1 to 0.
- R9: Only the first chip-select window after a reset streams. Later windows set `cmd_mode` and leave `io_oe` at 0.
- R10: A hardware reset pulse (`hw_rst_n`) or a `soft_rst` pulse re-arms the boot stream and keeps the configuration word. Only `por_n` restores the default.
- R11: When chip select rises, streaming stops, `io_oe` returns to 0 and `boot_busy` falls.
- R12: `boot_err` is set when chip select rises during the dummy phase, or before the rising edge that samples the last unit of the first byte. It stays set until any reset. A window that delivers exactly one full byte leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| por_n | input | 1 | Power-on reset, active low, asynchronous; resets the configuration word |
| hw_rst_n | input | 1 | Hardware reset pin, active low, asynchronous; re-arms |
| soft_rst | input | 1 | One-cycle software reset request; re-arms and clears the error |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write value |
| cfg_q | output | 32 | Current configuration word |
| mem_we | input | 1 | Byte array write strobe |
| mem_waddr | input | ADDR_W | Byte array write address |
| mem_wdata | input | 8 | Byte array write data |
| quad_en | input | 1 | Lane-mode select, 1 = four lanes |
| sclk | input | 1 | Serial clock (idle low) |
| cs_n | input | 1 | Chip select, active low |
| io_out | output | 4 | Serial data lanes |
| io_oe | output | 4 | Per-lane output enable |
| boot_busy | output | 1 | Boot window in dummy or stream phase |
| cmd_mode | output | 1 | Current window handed to command decoding |
| boot_err | output | 1 | Sticky short-window error |

## Verification
The hardest situations to reach from the ports are the ones a normal host never produces. One is a window that ends partway through the first byte. Another is a quad-enable change inside a window that is already running. The stimulus drives the serial clock by hand, one pulse at a time. This lets it end a window after an exact number of rising edges: inside the dummy phase, after one quad nibble, or right after the last unit of the first byte. It also flips `quad_en` between the dummy phase and the data phase. A sweep over all four delay codes and both lane modes uses a different start block in each case, with junk in the ignored configuration bits. Expected bytes come from the arithmetic pattern that was loaded into the array.

// File: rtl/fb_pkg.sv
package fb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DUMMY  = 2'd1,
    ST_STREAM = 2'd2,
    ST_CMD    = 2'd3
  } fb_state_e;

  // rising-edge count before the first data unit: 6 + 2*code
  function automatic logic [3:0] fb_dummy_len(input logic [1:0] code);
    return 4'd6 + {1'b0, code, 1'b0};
  endfunction

endpackage

// File: rtl/fb_rst_sync.sv
module fb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ns
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_ns = chain_q[STAGES-1];

endmodule

// File: rtl/fb_cfg_reg.sv
module fb_cfg_reg #(
  parameter int          W       = 32,
  parameter logic [31:0] DEFAULT = 32'hFFFF_FFFF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  logic [W-1:0] nxt;

  always_comb begin
    nxt = q;
    if (we) nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= DEFAULT[W-1:0];
    else        q <= nxt;
  end

endmodule

// File: rtl/fb_mem.sv
module fb_mem #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
  end

  assign rdata = arr[raddr];

endmodule

// File: rtl/fb_stream.sv
module fb_stream
  import fb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              sclk,
  input  logic              cs_n,
  input  logic              quad_en,
  input  logic              boot_en,
  input  logic [1:0]        dly_code,
  input  logic [ADDR_W-5:0] start_blk,
  output logic [ADDR_W-1:0] mem_raddr,
  input  logic [7:0]        mem_rdata,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              boot_busy,
  output logic              cmd_mode,
  output logic              boot_err
);

  localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  fb_state_e         state, n_state;
  logic              sclk_r, sclk_rr, csn_r, csn_rr;
  logic [3:0]        dcnt, n_dcnt;
  logic [2:0]        pos, n_pos;
  logic [2:0]        ucnt, n_ucnt;
  logic              byte_ok, n_byte_ok;
  logic [7:0]        sh, n_sh;
  logic [ADDR_W-1:0] addr, n_addr;
  logic              quad_q, n_quad;
  logic              armed, n_armed;
  logic              err, n_err;
  logic [3:0]        out_q, n_out;

  logic sc_rise, sc_fall, cs_fall, cs_rise;
  logic [2:0] last_unit;

  assign sc_rise   = sclk_r & ~sclk_rr;
  assign sc_fall   = ~sclk_r & sclk_rr;
  assign cs_fall   = ~csn_r & csn_rr;
  assign cs_rise   = csn_r & ~csn_rr;
  assign last_unit = quad_q ? 3'd1 : 3'd7;
  assign mem_raddr = addr;

  always_comb begin
    n_state   = state;
    n_dcnt    = dcnt;
    n_pos     = pos;
    n_ucnt    = ucnt;
    n_byte_ok = byte_ok;
    n_sh      = sh;
    n_addr    = addr;
    n_quad    = quad_q;
    n_armed   = armed;
    n_err     = err;
    n_out     = out_q;
    if (soft_rst) begin
      n_state = ST_IDLE;
      n_armed = 1'b1;
      n_err   = 1'b0;
    end else if (cs_rise) begin
      if (state == ST_DUMMY || (state == ST_STREAM && !byte_ok)) n_err = 1'b1;
      n_state = ST_IDLE;
    end else if (cs_fall) begin
      n_armed = 1'b0;
      if (armed && boot_en) begin
        n_state   = ST_DUMMY;
        n_dcnt    = 4'd0;
        n_quad    = quad_en;
        n_addr    = {start_blk, 4'b0000};
        n_byte_ok = 1'b0;
        n_ucnt    = 3'd0;
      end else begin
        n_state = ST_CMD;
      end
    end else begin
      case (state)
        ST_DUMMY: begin
          if (sc_rise) begin
            if (dcnt == fb_dummy_len(dly_code) - 4'd1) begin
              n_state = ST_STREAM;
              n_sh    = mem_rdata;
              n_addr  = addr + ADDR_ONE;
              n_pos   = 3'd0;
              n_out   = 4'd0;
            end else begin
              n_dcnt = dcnt + 4'd1;
            end
          end
        end
        ST_STREAM: begin
          if (sc_fall) begin
            n_out = quad_q ? sh[7:4] : {2'b00, sh[7], 1'b0};
            if (pos == last_unit) begin
              n_sh   = mem_rdata;
              n_addr = addr + ADDR_ONE;
              n_pos  = 3'd0;
            end else begin
              n_sh  = quad_q ? {sh[3:0], 4'b0000} : {sh[6:0], 1'b0};
              n_pos = pos + 3'd1;
            end
          end
          if (sc_rise && !byte_ok) begin
            if (ucnt == last_unit) n_byte_ok = 1'b1;
            else                   n_ucnt    = ucnt + 3'd1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_r  <= 1'b0;
      sclk_rr <= 1'b0;
      csn_r   <= 1'b1;
      csn_rr  <= 1'b1;
      state   <= ST_IDLE;
      dcnt    <= '0;
      pos     <= '0;
      ucnt    <= '0;
      byte_ok <= 1'b0;
      sh      <= '0;
      addr    <= '0;
      quad_q  <= 1'b0;
      armed   <= 1'b1;
      err     <= 1'b0;
      out_q   <= '0;
    end else begin
      sclk_r  <= sclk;
      sclk_rr <= sclk_r;
      csn_r   <= cs_n;
      csn_rr  <= csn_r;
      state   <= n_state;
      dcnt    <= n_dcnt;
      pos     <= n_pos;
      ucnt    <= n_ucnt;
      byte_ok <= n_byte_ok;
      sh      <= n_sh;
      addr    <= n_addr;
      quad_q  <= n_quad;
      armed   <= n_armed;
      err     <= n_err;
      out_q   <= n_out;
    end
  end

  assign io_out    = out_q;
  assign io_oe     = (state == ST_STREAM) ? (quad_q ? 4'b1111 : 4'b0010) : 4'b0000;
  assign boot_busy = (state == ST_DUMMY) || (state == ST_STREAM);
  assign cmd_mode  = (state == ST_CMD);
  assign boot_err  = err;

endmodule

// File: rtl/fast_boot_resp.sv
module fast_boot_resp #(
  parameter int ADDR_W   = 8,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              hw_rst_n,
  input  logic              soft_rst,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_q,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_waddr,
  input  logic [7:0]        mem_wdata,
  input  logic              quad_en,
  input  logic              sclk,
  input  logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  output logic              boot_busy,
  output logic              cmd_mode,
  output logic              boot_err
);

  logic              por_ns, rst_ns;
  logic              any_rst_n;
  logic [ADDR_W-1:0] mem_raddr;
  logic [7:0]        mem_rdata;

  assign any_rst_n = por_n & hw_rst_n;

  fb_rst_sync #(.STAGES(SYNC_STG)) u_por_sync (
    .clk(clk), .arst_n(por_n), .rst_ns(por_ns));

  fb_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk(clk), .arst_n(any_rst_n), .rst_ns(rst_ns));

  fb_cfg_reg #(.W(32), .DEFAULT(32'hFFFF_FFFF)) u_cfg (
    .clk(clk), .rst_n(por_ns), .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q));

  fb_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata));

  fb_stream #(.ADDR_W(ADDR_W)) u_stream (
    .clk       (clk),
    .rst_n     (rst_ns),
    .soft_rst  (soft_rst),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .quad_en   (quad_en),
    .boot_en   (~cfg_q[0]),
    .dly_code  (cfg_q[2:1]),
    .start_blk (cfg_q[ADDR_W-1:4]),
    .mem_raddr (mem_raddr),
    .mem_rdata (mem_rdata),
    .io_out    (io_out),
    .io_oe     (io_oe),
    .boot_busy (boot_busy),
    .cmd_mode  (cmd_mode),
    .boot_err  (boot_err));

endmodule

// File: rtl/fast_boot_resp_chk.sv
module fast_boot_resp_chk (
  input logic        clk,
  input logic        rst_ns,
  input logic        por_ns,
  input logic        cs_n,
  input logic        cfg_we,
  input logic [31:0] cfg_q,
  input logic [3:0]  io_oe,
  input logic        boot_busy,
  input logic        cmd_mode,
  input logic        boot_err
);

  // R5 / R6: only the one-lane or the four-lane enable pattern is legal
  p_oe_pattern_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    ($countones(io_oe) == 0) || (io_oe == 4'b0010) || (io_oe == 4'b1111));

  // R7: the lane mode does not change while data is being driven
  p_lane_hold_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    ((io_oe != 4'b0000) && ($past(io_oe) != 4'b0000)) |-> $stable(io_oe));

  // R9: a window is either a boot stream or a command window, never both
  p_mode_excl_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    !(boot_busy && cmd_mode));

  // R11: a chip select held high leaves the boot window closed
  p_cs_high_idle_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    ($past(cs_n) && cs_n) |=> (!boot_busy && io_oe == 4'b0000));

  // R12: the error flag only rises at the end of a boot window
  p_err_source_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(boot_err) |-> $past(boot_busy));

  // R10: the configuration word changes only on a write
  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!por_ns)
    !cfg_we |=> $stable(cfg_q));

endmodule

bind fast_boot_resp fast_boot_resp_chk chk_i (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .por_ns    (por_ns),
  .cs_n      (cs_n),
  .cfg_we    (cfg_we),
  .cfg_q     (cfg_q),
  .io_oe     (io_oe),
  .boot_busy (boot_busy),
  .cmd_mode  (cmd_mode),
  .boot_err  (boot_err));

// File: tb/fast_boot_resp_tb_top.sv
`timescale 1ns/1ps
module fast_boot_resp_tb_top;

  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          por_n, hw_rst_n, soft_rst;
  logic          cfg_we;
  logic [31:0]   cfg_wdata, cfg_q;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [7:0]    mem_wdata;
  logic          quad_en, sclk, cs_n;
  logic [3:0]    io_out, io_oe;
  logic          boot_busy, cmd_mode, boot_err;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  fast_boot_resp #(.ADDR_W(AW)) dut_i (
    .clk(clk), .por_n(por_n), .hw_rst_n(hw_rst_n), .soft_rst(soft_rst),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .quad_en(quad_en), .sclk(sclk), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .boot_busy(boot_busy),
    .cmd_mode(cmd_mode), .boot_err(boot_err));

  function automatic logic [7:0] pat(input int a);
    return 8'((((a % 256) * 37) + 5) % 256);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; wclk(4);
    sclk = 1'b0; wclk(4);
  endtask

  task automatic write_cfg(input logic [31:0] v);
    cfg_we = 1'b1; cfg_wdata = v; wclk(1);
    cfg_we = 1'b0; wclk(1);
  endtask

  task automatic do_soft();
    soft_rst = 1'b1; wclk(1);
    soft_rst = 1'b0; wclk(2);
  endtask

  task automatic do_hw();
    hw_rst_n = 1'b0; wclk(3);
    hw_rst_n = 1'b1; wclk(6);
  endtask

  task automatic do_por();
    por_n = 1'b0; wclk(3);
    por_n = 1'b1; wclk(6);
  endtask

  // one boot window; expects streaming of nbytes from blk*16
  task automatic run_boot(input int code, input int blk, input bit quad,
                          input int nbytes, input bit flip, input string req);
    int n, upb;
    logic [7:0] rx;
    n   = 6 + 2 * code;
    upb = quad ? 2 : 8;
    quad_en = quad;
    cs_n = 1'b0; wclk(4);
    for (int i = 0; i < n - 1; i++) pulse();
    check(io_oe == 4'b0000 && boot_busy, "R3 still in dummy", {28'd0, io_oe}, 32'd0);
    pulse();
    if (flip) quad_en = ~quad;
    for (int b = 0; b < nbytes; b++) begin
      rx = 8'd0;
      for (int u = 0; u < upb; u++) begin
        if (u == 0)
          check(io_oe == (quad ? 4'b1111 : 4'b0010), quad ? "R6 oe" : "R5 oe",
                {28'd0, io_oe}, quad ? 32'hF : 32'h2);
        rx = quad ? {rx[3:0], io_out} : {rx[6:0], io_out[1]};
        pulse();
      end
      check(rx == pat(blk * 16 + b), {req, " byte"}, {24'd0, rx},
            {24'd0, pat(blk * 16 + b)});
    end
    cs_n = 1'b1; wclk(6);
    check(io_oe == 4'b0000 && !boot_busy && !boot_err, "R11 released",
          {27'd0, boot_err, io_oe}, 32'd0);
    quad_en = 1'b0;
  endtask

  task automatic cmd_window(input string req);
    cs_n = 1'b0; wclk(4);
    for (int i = 0; i < 14; i++) pulse();
    check(cmd_mode && io_oe == 4'b0000 && !boot_busy, req,
          {27'd0, cmd_mode, io_oe}, 32'h10);
    cs_n = 1'b1; wclk(6);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    por_n = 1'b0; hw_rst_n = 1'b1; soft_rst = 1'b0;
    cfg_we = 1'b0; cfg_wdata = '0; mem_we = 1'b0; mem_waddr = '0; mem_wdata = '0;
    quad_en = 1'b0; sclk = 1'b0; cs_n = 1'b1;
    wclk(4); por_n = 1'b1; wclk(6);

    check(cfg_q == 32'hFFFF_FFFF, "R1 default cfg", cfg_q, 32'hFFFF_FFFF);
    check(!boot_err && io_oe == 4'b0000 && !boot_busy, "R1 reset outputs",
          {27'd0, boot_err, io_oe}, 32'd0);

    for (int a = 0; a < 256; a++) begin
      mem_we = 1'b1; mem_waddr = AW'(a); mem_wdata = pat(a); wclk(1);
    end
    mem_we = 1'b0; wclk(1);

    cmd_window("R1 default disabled");

    // R2: enable bit set to 1 with other fields valid -> no stream
    write_cfg(32'h0000_0037);
    do_soft();
    cmd_window("R2 bit0=1 disabled");

    // sweep delay codes and lane modes, junk in ignored bits (R4)
    for (int c = 0; c < 4; c++) begin
      for (int q = 0; q < 2; q++) begin
        int blk;
        blk = (c * 5 + q * 3 + 1) % 16;
        write_cfg(32'hABC0_0000 | 32'(blk << 4) | 32'h8 | 32'(c << 1));
        do_soft();
        run_boot(c, blk, q[0], 3, 1'b0, "R4 sweep");
        cmd_window("R9 second window");
      end
    end

    // R8 wrap at top of the array
    write_cfg(32'h0000_00F0);
    do_soft();
    run_boot(0, 15, 1'b0, 18, 1'b0, "R8 wrap");

    // R7 quad captured at window start, flipped after dummy
    write_cfg(32'h0000_0022);
    do_soft();
    run_boot(1, 2, 1'b1, 2, 1'b1, "R7 quad latched");
    do_soft();
    run_boot(1, 2, 1'b0, 2, 1'b1, "R7 single latched");

    // R12: window ends in dummy
    write_cfg(32'h0000_0040);
    do_soft();
    cs_n = 1'b0; wclk(4);
    pulse(); pulse();
    cs_n = 1'b1; wclk(6);
    check(boot_err, "R12 end in dummy", {31'd0, boot_err}, 32'd1);
    do_soft();
    check(!boot_err, "R12 cleared by soft reset", {31'd0, boot_err}, 32'd0);

    // R12: quad window ends after one nibble
    cs_n = 1'b0; quad_en = 1'b1; wclk(4);
    for (int i = 0; i < 7; i++) pulse();
    cs_n = 1'b1; wclk(6);
    check(boot_err, "R12 partial byte", {31'd0, boot_err}, 32'd1);
    quad_en = 1'b0;

    // R10: hardware reset keeps cfg, clears error, re-arms
    do_hw();
    check(cfg_q == 32'h0000_0040, "R10 cfg kept on hw reset", cfg_q, 32'h40);
    check(!boot_err, "R12 cleared by hw reset", {31'd0, boot_err}, 32'd0);
    run_boot(0, 4, 1'b0, 1, 1'b0, "R10 hw rearm");
    check(!boot_err, "R12 one full byte is enough", {31'd0, boot_err}, 32'd0);

    // quad, exactly one byte
    do_hw();
    run_boot(0, 4, 1'b1, 1, 1'b0, "R6 single quad byte");

    // R10: power-on reset restores default
    do_por();
    check(cfg_q == 32'hFFFF_FFFF, "R10 por default", cfg_q, 32'hFFFF_FFFF);
    cmd_window("R10 por disables");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule